// File: doc/BRIEF.md
# DRAM Bank Open-State Tracker

This block follows a decoded DRAM command stream from a memory controller and keeps the open or idle state of each of eight banks. It accepts one command per clock, qualified by a valid strobe. An activate opens a bank. A precharge closes one bank or all banks, chosen by the auto-precharge address bit. Reads and writes are checked against the open state. Refresh is checked against the all-banks-idle condition.

After a bank closes, a per-bank countdown, loaded from a precharge-delay value that can be changed at run time, blocks a new activate to that bank until the delay has passed. Any illegal command raises an error flag with a cause code for one cycle, and the state is left as it was. The block also drives a status pin that says every bank is idle and no countdown is pending, which a scheduler can use before a refresh.

The command input has no back-pressure. The tracker takes a command on every cycle in which `cmd_valid` is high, so the controller must never hold a command. No ready signal exists, and a command presented with `cmd_valid` low is dropped.

Top module: `bank_state_tracker`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, every `bank_open` bit is 0, `all_idle` is 1, `err_flag` is 0 and `err_code` is 0.
- R2: An activate (`cmd_op` = 1) to a bank that is idle and has no countdown pending sets that bank's `bank_open` bit after the clock edge, with no error.
- R3: A precharge (`cmd_op` = 4) with `cmd_a10` = 0 closes only the bank named by `cmd_bank`. Precharging a bank that is already idle changes no state and does not restart its countdown.
- R4: A precharge with `cmd_a10` = 1 closes every open bank and ignores `cmd_bank`.
- R5: A read (`cmd_op` = 2) or write (`cmd_op` = 3) to an idle bank gives `err_code` = 1. To an open bank it gives no error and no change of state. `cmd_a10` has no effect on reads and writes.
- R6: An activate to a bank that is already open gives `err_code` = 2 and leaves `bank_open` unchanged.
- R7: Let T = `trp_cycles`, or 1 when `trp_cycles` is 0. A bank closed by a precharge on edge k accepts an activate on edge k+T or later. An activate on an earlier edge gives `err_code` = 2 and does not open the bank.
- R8: `all_idle` is 1 exactly when no bank is open and no bank's countdown is pending. It rises T-1 cycles after the edge of the last precharge.
- R9: A refresh (`cmd_op` = 5) while `all_idle` is 0 gives `err_code` = 3. While `all_idle` is 1 it gives no error. A refresh never changes bank state.
- R10: With `cmd_valid` low, and for any `cmd_op` value of 0, 6 or 7, the command has no effect on state and raises no error.
- R11: `err_flag` is high, with a nonzero `err_code`, only in the single cycle after an illegal command's edge. Otherwise `err_flag` and `err_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trp_cycles | input | 6 | Precharge-to-activate delay in cycles; 0 counts as 1 |
| cmd_valid | input | 1 | Command qualifier; no back-pressure |
| cmd_op | input | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6/7 reserved |
| cmd_bank | input | 3 | Target bank |
| cmd_a10 | input | 1 | On precharge: 1 closes all banks |
| bank_open | output | 8 | One bit per bank, 1 = open |
| all_idle | output | 1 | All banks closed and no countdown pending |
| err_flag | output | 1 | Illegal command seen on previous edge |
| err_code | output | 2 | 1 access to idle bank, 2 activate conflict, 3 refresh while busy |

## Verification
A wrong open bit appears on `bank_open` after the edge that set it wrongly. It also shows as a false or missing `err_code` the first time a read, write or activate touches that bank. A countdown loaded or decremented wrongly does not show on `bank_open`. It shows on `all_idle` one cycle early or late, and as an activate error on the wrong edge. The bench therefore compares every output against a behavioural model on every clock and steps activates through the exact edge where the delay ends.

// File: rtl/bst_pkg.sv
package bst_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_REF  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_IDLE_ACC  = 2'd1,
    ERR_ACT_CONF  = 2'd2,
    ERR_REF_BUSY  = 2'd3
  } err_e;

endpackage

// File: rtl/bst_cmd_decode.sv
module bst_cmd_decode #(
  parameter int BANK_AW = 3,
  localparam int NB = 1 << BANK_AW
) (
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [BANK_AW-1:0] cmd_bank,
  input  logic               cmd_a10,
  output logic               is_act,
  output logic               is_rw,
  output logic               is_pre,
  output logic               is_ref,
  output logic [NB-1:0]      bank_sel,
  output logic [NB-1:0]      pre_mask
);
  import bst_pkg::*;

  always_comb begin
    is_act = 1'b0;
    is_rw  = 1'b0;
    is_pre = 1'b0;
    is_ref = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_ACT:        is_act = 1'b1;
        OP_RD, OP_WR:  is_rw  = 1'b1;
        OP_PRE:        is_pre = 1'b1;
        OP_REF:        is_ref = 1'b1;
        default: ;
      endcase
    end
  end

  // one-hot bank select
  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_sel
      assign bank_sel[g] = (cmd_bank == BANK_AW'(g));
    end
  endgenerate

  // with a10 set, the bank address plays no part in a precharge
  always_comb begin
    if (cmd_a10) pre_mask = '1;
    else         pre_mask = bank_sel;
  end

endmodule

// File: rtl/bst_bank_slot.sv
module bst_bank_slot #(
  parameter int TRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic [TRP_W-1:0] trp_load,
  output logic             open_o,
  output logic             ready_o,
  output logic             counting_o
);
  logic             open_q;
  logic [TRP_W-1:0] cnt_q;
  logic             close_now;

  // only an open bank is closed; an idle bank keeps its countdown
  assign close_now = pre_go && open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (act_go)         open_q <= 1'b1;
      else if (close_now) open_q <= 1'b0;

      if (close_now)          cnt_q <= trp_load;
      else if (cnt_q != '0)   cnt_q <= cnt_q - TRP_W'(1);
    end
  end

  assign open_o     = open_q;
  assign counting_o = (cnt_q != '0);
  assign ready_o    = !open_q && (cnt_q == '0);

  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !close_now) |=> (cnt_q == $past(cnt_q) - TRP_W'(1)));

  a_r8_open_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (cnt_q == '0));

  a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> open_q);

  a_r3_close_loads: assert property (@(posedge clk) disable iff (!rst_n)
    close_now |=> (!open_q && cnt_q == $past(trp_load)));

endmodule

// File: rtl/bst_rule_check.sv
module bst_rule_check #(
  parameter int NB = 8
) (
  input  logic          is_act,
  input  logic          is_rw,
  input  logic          is_ref,
  input  logic [NB-1:0] bank_sel,
  input  logic [NB-1:0] open_vec,
  input  logic [NB-1:0] ready_vec,
  input  logic          idle_now,
  output logic [NB-1:0] act_go,
  output logic          err_hit,
  output logic [1:0]    err_kind
);
  import bst_pkg::*;

  logic sel_open, sel_ready;

  assign sel_open  = |(bank_sel & open_vec);
  assign sel_ready = |(bank_sel & ready_vec);
  assign act_go    = {NB{is_act}} & bank_sel & ready_vec;

  always_comb begin
    err_hit  = 1'b0;
    err_kind = ERR_NONE;
    if (is_rw && !sel_open) begin
      err_hit  = 1'b1;
      err_kind = ERR_IDLE_ACC;
    end else if (is_act && !sel_ready) begin
      err_hit  = 1'b1;
      err_kind = ERR_ACT_CONF;
    end else if (is_ref && !idle_now) begin
      err_hit  = 1'b1;
      err_kind = ERR_REF_BUSY;
    end
  end

  // R10: at most one command class is active at once
  always_comb begin
    a_r10_one_class: assert ($countones({is_act, is_rw, is_ref}) <= 1);
  end

endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker #(
  parameter int BANK_AW = 3,
  parameter int TRP_W   = 6,
  localparam int NB     = 1 << BANK_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TRP_W-1:0]   trp_cycles,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [BANK_AW-1:0] cmd_bank,
  input  logic               cmd_a10,
  output logic [NB-1:0]      bank_open,
  output logic               all_idle,
  output logic               err_flag,
  output logic [1:0]         err_code
);
  import bst_pkg::*;

  logic          is_act, is_rw, is_pre, is_ref;
  logic [NB-1:0] bank_sel, pre_mask;
  logic [NB-1:0] open_vec, ready_vec, counting_vec, act_go;
  logic [TRP_W-1:0] trp_eff, trp_load;
  logic          err_hit;
  logic [1:0]    err_kind;
  logic          err_q;
  logic [1:0]    code_q;
  logic          idle_now;

  // a zero delay is treated as one cycle; the slot counts the remainder
  assign trp_eff  = (trp_cycles == '0) ? TRP_W'(1) : trp_cycles;
  assign trp_load = trp_eff - TRP_W'(1);

  bst_cmd_decode #(.BANK_AW(BANK_AW)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cmd_a10   (cmd_a10),
    .is_act    (is_act),
    .is_rw     (is_rw),
    .is_pre    (is_pre),
    .is_ref    (is_ref),
    .bank_sel  (bank_sel),
    .pre_mask  (pre_mask)
  );

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_bank
      bst_bank_slot #(.TRP_W(TRP_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_go     (act_go[g]),
        .pre_go     (is_pre && pre_mask[g]),
        .trp_load   (trp_load),
        .open_o     (open_vec[g]),
        .ready_o    (ready_vec[g]),
        .counting_o (counting_vec[g])
      );
    end
  endgenerate

  assign idle_now = !(|open_vec) && !(|counting_vec);

  bst_rule_check #(.NB(NB)) u_rules (
    .is_act    (is_act),
    .is_rw     (is_rw),
    .is_ref    (is_ref),
    .bank_sel  (bank_sel),
    .open_vec  (open_vec),
    .ready_vec (ready_vec),
    .idle_now  (idle_now),
    .act_go    (act_go),
    .err_hit   (err_hit),
    .err_kind  (err_kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      err_q  <= err_hit;
      code_q <= err_kind;
    end
  end

  assign bank_open = open_vec;
  assign all_idle  = idle_now;
  assign err_flag  = err_q;
  assign err_code  = code_q;

  a_r11_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag == (err_code != 2'd0));

  a_r4_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PRE && cmd_a10) |=> (bank_open == '0));

  a_r5_rw_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && !bank_open[cmd_bank])
      |=> (err_flag && err_code == ERR_IDLE_ACC));

  a_r6_act_open_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACT && bank_open[cmd_bank])
      |=> ($stable(bank_open) && err_code == ERR_ACT_CONF));

  a_r9_ref_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_REF) |=> $stable(bank_open));

  a_r10_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid) |=> (!err_flag && $stable(bank_open)));

endmodule

// File: tb/tb_bank_state_tracker.sv
`timescale 1ns/1ps
module tb_bank_state_tracker;
  localparam int AW = 3;
  localparam int NB = 8;
  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [TW-1:0] trp_cycles;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_bank;
  logic          cmd_a10;
  logic [NB-1:0] bank_open;
  logic          all_idle;
  logic          err_flag;
  logic [1:0]    err_code;

  always #2 clk = ~clk;

  bank_state_tracker #(.BANK_AW(AW), .TRP_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .trp_cycles(trp_cycles),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_a10(cmd_a10), .bank_open(bank_open), .all_idle(all_idle),
    .err_flag(err_flag), .err_code(err_code)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  int  m_open [NB];
  int  m_cnt  [NB];
  int  m_code = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int model_idle();
    for (int i = 0; i < NB; i++)
      if (m_open[i] != 0 || m_cnt[i] != 0) return 0;
    return 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin
      m_open[i] = 0;
      m_cnt[i]  = 0;
    end
    m_code = 0;
  endtask

  // behavioural model of one clock edge
  task automatic model_edge(bit v, int op, int b, bit a10, int trp);
    int t;
    int was_idle;
    int old_open [NB];
    int old_cnt  [NB];
    t = (trp == 0) ? 1 : trp;
    was_idle = model_idle();
    for (int i = 0; i < NB; i++) begin
      old_open[i] = m_open[i];
      old_cnt[i]  = m_cnt[i];
      if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
    end
    m_code = 0;
    if (v) begin
      case (op)
        1: if (old_open[b] == 0 && old_cnt[b] == 0) m_open[b] = 1;
           else m_code = 2;
        2, 3: if (old_open[b] == 0) m_code = 1;
        4: for (int i = 0; i < NB; i++)
             if ((a10 || i == b) && old_open[i] != 0) begin
               m_open[i] = 0;
               m_cnt[i]  = t - 1;
             end
        5: if (!was_idle) m_code = 3;
        default: ;
      endcase
    end
  endtask

  task automatic compare(string tag);
    int exp_vec;
    exp_vec = 0;
    for (int i = 0; i < NB; i++) if (m_open[i] != 0) exp_vec |= (1 << i);
    chk(tag, "bank_open", int'(bank_open), exp_vec);
    chk(tag, "all_idle",  int'(all_idle),  model_idle());
    chk(tag, "err_flag",  int'(err_flag),  (m_code != 0) ? 1 : 0);
    chk(tag, "err_code",  int'(err_code),  m_code);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(string tag, bit v, int op, int b, bit a10);
    cmd_valid = v;
    cmd_op    = op[2:0];
    cmd_bank  = b[AW-1:0];
    cmd_a10   = a10;
    @(posedge clk);
    model_edge(v, op, b, a10, int'(trp_cycles));
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; trp_cycles = 6'd3;
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_bank = '0; cmd_a10 = 1'b0;
    model_reset();
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0);

    // open, access, conflict
    step("R2", 1, 1, 0, 0);
    step("R2", 1, 1, 5, 0);
    step("R5", 1, 2, 0, 1);
    step("R5", 1, 3, 2, 0);   // write to idle bank 2 -> code 1
    step("R11", 0, 0, 0, 0);  // flag falls again
    step("R6", 1, 1, 0, 0);   // activate open bank -> code 2

    // single precharge and the delay window (T = 3)
    step("R3", 1, 4, 0, 0);
    step("R7", 1, 1, 0, 0);   // edge k+1: too early
    step("R7", 0, 0, 0, 0);
    step("R7", 1, 1, 0, 0);   // edge k+3: legal

    // precharge all, bank field ignored
    step("R4", 1, 4, 3, 1);
    step("R9", 1, 5, 0, 0);   // countdown pending -> code 3
    step("R8", 0, 0, 0, 0);
    step("R9", 1, 5, 0, 0);   // idle -> no error

    // ignored commands
    step("R10", 0, 1, 1, 0);
    step("R10", 1, 6, 1, 0);
    step("R10", 1, 7, 1, 1);

    // precharge of an idle bank does not restart its countdown
    trp_cycles = 6'd4;
    step("R2", 1, 1, 2, 0);
    step("R3", 1, 4, 2, 0);
    step("R3", 1, 4, 2, 0);
    step("R7", 0, 0, 0, 0);
    step("R7", 1, 1, 2, 0);   // edge k+3 < k+4: error
    step("R7", 1, 1, 2, 0);   // edge k+4: legal

    // zero delay behaves as one cycle
    trp_cycles = 6'd0;
    step("R4", 1, 4, 0, 1);
    step("R2", 1, 1, 1, 0);
    step("R3", 1, 4, 1, 0);
    step("R7", 1, 1, 1, 0);

    // long pseudo-random stream against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:12] == 4'd0) trp_cycles = TW'(lfsr[2:0]);
      op = int'(lfsr[6:4]);
      if (lfsr[9:8] == 2'b00) op = 4;
      step("R8", lfsr[11] | lfsr[7], op, int'(lfsr[2:0]), lfsr[3] & lfsr[10]);
    end

    done = 1;
    finish_run();
  end

endmodule